// File: doc/BRIEF.md
# Command/Address Bus Driver with Mode-Register Snooping

This block sits between the frequency-ratio conversion stage and the memory device pins. Each cycle it registers the 14-bit command/address word and the active-low chip select and drives them onto the bus one cycle later. While the words pass through, it watches the command stream for two kinds of command.

A mode-register write takes two consecutive bus cycles: the first holds the register address and the second holds 8 data bits. When the address is one the block tracks, it updates its local copy of the burst-length choice, the preamble and postamble settings, or the write-CRC enable. The write data path reads these settings directly. A write command raises a one-cycle start pulse toward the write data path. The pulse carries the burst length for that write, which is either the default BL16 or the alternative length held in the stored mode setting, and the CRC enable state at that moment.

The encoding is simplified. A command is decoded only when chip select is low. Its opcode sits in CA[2:0]: `100` is a write and `110` is a mode-register write. For a mode-register write the address sits in CA[10:3], and the data of the following cycle sits in CA[7:0]. CA[3] of a write picks the alternative burst length.

Top module: `ca_cmd_decoder`

## Requirements
- R1: `caOut` and `csNOut` equal `caIn` and `csNIn` from the previous clock edge. The latency is fixed at one cycle.
- R2: While `rstN` is low: `caOut` is 0, `csNOut` is 1, `wrStart` is 0, `cfgBurst8` is 0 (BL16), `cfgPreamble` is 1 (2-cycle), `cfgPostamble` is 0 (0.5-cycle) and `cfgCrcEn` is 0.
- R3: A word presented with `csNIn` high is never decoded as a command, whatever its CA[2:0] value.
- R4: A mode-register write to address 0x00 sets `cfgBurst8` to data bit 0 (1 = BL8, 0 = BL16). The new value shows one cycle after the data word is presented.
- R5: A mode-register write to address 0x08 sets `cfgPreamble` to data[2:0] and `cfgPostamble` to data[7:6].
- R6: A mode-register write to address 0x32 sets `cfgCrcEn` to data bit 0.
- R7: A mode-register write to any other address is forwarded unchanged and leaves all stored settings as they were.
- R8: A write command gives `wrStart` high for exactly the next cycle. With CA[3]=0, `wrBurst8` is 0 (default BL16). With CA[3]=1, `wrBurst8` is the stored `cfgBurst8`.
- R9: With a write's start pulse, `wrCrcEn` equals `cfgCrcEn` as it stood when the write was presented.
- R10: The data cycle of a mode-register write is never decoded as a command, even when chip select is low and CA[2:0] looks like a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| caIn | input | 14 | Command/address word from the ratio stage |
| csNIn | input | 1 | Active-low chip select from the ratio stage |
| caOut | output | 14 | Registered command/address bus |
| csNOut | output | 1 | Registered active-low chip select |
| wrStart | output | 1 | One-cycle pulse per decoded write |
| wrBurst8 | output | 1 | Burst of the started write: 1 = BL8, 0 = BL16 |
| wrCrcEn | output | 1 | CRC enable of the started write |
| cfgBurst8 | output | 1 | Stored alternative burst length, 1 = BL8 |
| cfgPreamble | output | 3 | Stored preamble code |
| cfgPostamble | output | 2 | Stored postamble code |
| cfgCrcEn | output | 1 | Stored write-CRC enable |

## Verification
The assertions assume that a mode-register write is always followed directly by its data word. They also assume that no input changes near the clock edge. Any word that follows a mode-register write is treated as its data, so the checks on stored settings depend on that pairing. The stimulus changes inputs only on the falling edge. It always places the data word in the cycle right after the address word, and it places one data word that looks like a write in that slot on purpose.

// File: rtl/ca_decode_pkg.sv
package ca_decode_pkg;
  localparam int CA_W  = 14;
  localparam int OPC_W = 3;
  localparam int MRA_W = 8;
  localparam int MRD_W = 8;
  localparam int PRE_W = 3;
  localparam int POST_W = 2;
  localparam int ALT_BIT = 3;
  localparam int POST_LSB = 6;

  localparam logic [OPC_W-1:0] OPC_WRITE = 3'b100;
  localparam logic [OPC_W-1:0] OPC_MRW   = 3'b110;

  localparam logic [MRA_W-1:0] MRA_BURST = 8'h00;
  localparam logic [MRA_W-1:0] MRA_AMBLE = 8'h08;
  localparam logic [MRA_W-1:0] MRA_CRC   = 8'h32;

  localparam logic [PRE_W-1:0]  PRE_RESET  = 3'd1;
  localparam logic [POST_W-1:0] POST_RESET = 2'd0;

  typedef struct packed {
    logic setBurst;
    logic setAmble;
    logic setCrc;
    logic issueWrite;
    logic useAlt;
  } ctlStrobe_t;
endpackage

// File: rtl/ca_decode_ctrl.sv
module ca_decode_ctrl
  import ca_decode_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             csNIn,
  input  logic [OPC_W-1:0] opcIn,
  input  logic             altIn,
  input  logic [MRA_W-1:0] addrIn,
  output ctlStrobe_t       strb
);
  logic             mrwPending;
  logic [MRA_W-1:0] mrwAddr;
  logic             cmdValid;
  logic             isMrw;

  always_comb begin
    cmdValid        = !csNIn && !mrwPending;
    isMrw           = cmdValid && (opcIn == OPC_MRW);
    strb.issueWrite = cmdValid && (opcIn == OPC_WRITE);
    strb.useAlt     = altIn;
    strb.setBurst   = mrwPending && (mrwAddr == MRA_BURST);
    strb.setAmble   = mrwPending && (mrwAddr == MRA_AMBLE);
    strb.setCrc     = mrwPending && (mrwAddr == MRA_CRC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mrwPending <= 1'b0;
      mrwAddr    <= '0;
    end else begin
      mrwPending <= isMrw;
      if (isMrw) mrwAddr <= addrIn;
    end
  end

  AST_CS_GATE: assert property (@(posedge clk) disable iff (!rstN)
    csNIn |-> !strb.issueWrite); // R3
  AST_DATA_NOT_CMD: assert property (@(posedge clk) disable iff (!rstN)
    mrwPending |-> !strb.issueWrite); // R10
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.setBurst, strb.setAmble, strb.setCrc})); // R7
endmodule

// File: rtl/ca_decode_dp.sv
module ca_decode_dp
  import ca_decode_pkg::*;
#(
  parameter int CA_WIDTH = CA_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CA_WIDTH-1:0] caIn,
  input  logic                csNIn,
  input  ctlStrobe_t          strb,
  output logic [CA_WIDTH-1:0] caOut,
  output logic                csNOut,
  output logic                wrStart,
  output logic                wrBurst8,
  output logic                wrCrcEn,
  output logic                cfgBurst8,
  output logic [PRE_W-1:0]    cfgPreamble,
  output logic [POST_W-1:0]   cfgPostamble,
  output logic                cfgCrcEn
);
  logic [MRD_W-1:0] mrData;
  assign mrData = caIn[MRD_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      caOut    <= '0;
      csNOut   <= 1'b1;
      wrStart  <= 1'b0;
      wrBurst8 <= 1'b0;
      wrCrcEn  <= 1'b0;
    end else begin
      caOut    <= caIn;
      csNOut   <= csNIn;
      wrStart  <= strb.issueWrite;
      wrBurst8 <= strb.issueWrite && strb.useAlt && cfgBurst8;
      wrCrcEn  <= strb.issueWrite && cfgCrcEn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgBurst8    <= 1'b0;
      cfgPreamble  <= PRE_RESET;
      cfgPostamble <= POST_RESET;
      cfgCrcEn     <= 1'b0;
    end else begin
      if (strb.setBurst) cfgBurst8 <= mrData[0];
      if (strb.setAmble) begin
        cfgPreamble  <= mrData[PRE_W-1:0];
        cfgPostamble <= mrData[POST_LSB +: POST_W];
      end
      if (strb.setCrc) cfgCrcEn <= mrData[0];
    end
  end

  AST_CA_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (caOut == $past(caIn)) && (csNOut == $past(csNIn))); // R1
  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.setBurst |=> $stable(cfgBurst8)); // R7
  AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.setCrc |=> $stable(cfgCrcEn)); // R7
  AST_AMBLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.setAmble |=> $stable(cfgPreamble) && $stable(cfgPostamble)); // R7
  AST_DEFAULT_BL: assert property (@(posedge clk) disable iff (!rstN)
    strb.issueWrite && !strb.useAlt |=> wrStart && !wrBurst8); // R8
  AST_CRC_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.issueWrite |=> wrCrcEn == $past(cfgCrcEn)); // R9
endmodule

// File: rtl/ca_cmd_decoder.sv
module ca_cmd_decoder
  import ca_decode_pkg::*;
#(
  parameter int CA_WIDTH = CA_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CA_WIDTH-1:0] caIn,
  input  logic                csNIn,
  output logic [CA_WIDTH-1:0] caOut,
  output logic                csNOut,
  output logic                wrStart,
  output logic                wrBurst8,
  output logic                wrCrcEn,
  output logic                cfgBurst8,
  output logic [PRE_W-1:0]    cfgPreamble,
  output logic [POST_W-1:0]   cfgPostamble,
  output logic                cfgCrcEn
);
  ctlStrobe_t strb;

  ca_decode_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .csNIn  (csNIn),
    .opcIn  (caIn[OPC_W-1:0]),
    .altIn  (caIn[ALT_BIT]),
    .addrIn (caIn[OPC_W +: MRA_W]),
    .strb   (strb)
  );

  ca_decode_dp #(.CA_WIDTH(CA_WIDTH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .caIn         (caIn),
    .csNIn        (csNIn),
    .strb         (strb),
    .caOut        (caOut),
    .csNOut       (csNOut),
    .wrStart      (wrStart),
    .wrBurst8     (wrBurst8),
    .wrCrcEn      (wrCrcEn),
    .cfgBurst8    (cfgBurst8),
    .cfgPreamble  (cfgPreamble),
    .cfgPostamble (cfgPostamble),
    .cfgCrcEn     (cfgCrcEn)
  );
endmodule

// File: tb/ca_cmd_decoder_tb.sv
`timescale 1ns/1ps
module ca_cmd_decoder_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:0] caIn = '0;
  logic        csNIn = 1'b1;
  logic [13:0] caOut;
  logic        csNOut, wrStart, wrBurst8, wrCrcEn, cfgBurst8, cfgCrcEn;
  logic [2:0]  cfgPreamble;
  logic [1:0]  cfgPostamble;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ca_cmd_decoder u_dut (
    .clk(clk), .rstN(rstN), .caIn(caIn), .csNIn(csNIn),
    .caOut(caOut), .csNOut(csNOut), .wrStart(wrStart), .wrBurst8(wrBurst8),
    .wrCrcEn(wrCrcEn), .cfgBurst8(cfgBurst8), .cfgPreamble(cfgPreamble),
    .cfgPostamble(cfgPostamble), .cfgCrcEn(cfgCrcEn)
  );

  typedef struct packed {
    logic        csN;
    logic [13:0] ca;
    logic        st;
    logic        b8;
    logic        crc;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 14'h0004, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 write opcode, CS high
    '{1'b0, 14'h000C, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 alt burst, still BL16
    '{1'b0, 14'h0006, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 MRW addr 0x00
    '{1'b1, 14'h0001, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 data: BL8
    '{1'b0, 14'h000C, 1'b1, 1'b1, 1'b0, 4'd4},  // R4 alt write now BL8
    '{1'b0, 14'h0004, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 default write BL16
    '{1'b0, 14'h0196, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 MRW addr 0x32
    '{1'b1, 14'h0001, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 data: CRC on
    '{1'b0, 14'h000C, 1'b1, 1'b1, 1'b1, 4'd9},  // R9 CRC carried
    '{1'b0, 14'h002E, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 MRW addr 0x05
    '{1'b0, 14'h0000, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 data ignored
    '{1'b0, 14'h000C, 1'b1, 1'b1, 1'b1, 4'd7},  // R7 settings kept
    '{1'b0, 14'h0006, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 MRW addr 0x00
    '{1'b0, 14'h000C, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 write-like data, CS low
    '{1'b0, 14'h000C, 1'b1, 1'b0, 1'b1, 4'd10}, // R10 burst back to BL16
    '{1'b1, 14'h3FFF, 1'b0, 1'b0, 1'b0, 4'd1}   // R1 idle all ones
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkReset();
    check(caOut == 14'h0 && csNOut == 1'b1, "R2", "bus idle",
          {csNOut, caOut}, {1'b1, 14'h0});
    check(!wrStart, "R2", "wrStart", wrStart, 0);
    check(!cfgBurst8 && cfgPreamble == 3'd1 && cfgPostamble == 2'd0 && !cfgCrcEn,
          "R2", "cfg defaults", {cfgBurst8, cfgPreamble, cfgPostamble, cfgCrcEn},
          {1'b0, 3'd1, 2'd0, 1'b0});
  endtask

  task automatic drive(input logic csN, input logic [13:0] ca);
    csNIn = csN;
    caIn  = ca;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkReset();
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      drive(VECS[i].csN, VECS[i].ca);
      check(caOut == VECS[i].ca && csNOut == VECS[i].csN, "R1", "bus forward",
            {csNOut, caOut}, {VECS[i].csN, VECS[i].ca});
      check(wrStart == VECS[i].st, tag, "wrStart", wrStart, VECS[i].st);
      if (VECS[i].st)
        check(wrBurst8 == VECS[i].b8 && wrCrcEn == VECS[i].crc, tag, "burst/crc",
              {wrBurst8, wrCrcEn}, {VECS[i].b8, VECS[i].crc});
    end
    // R8: start is a single-cycle pulse
    drive(1'b0, 14'h0004);
    drive(1'b1, 14'h0000);
    check(!wrStart, "R8", "pulse width", wrStart, 0);
    // R5: preamble/postamble through address 0x08
    drive(1'b0, 14'h0046);
    drive(1'b1, 14'h00C5);
    check(cfgPreamble == 3'd5 && cfgPostamble == 2'd3, "R5", "amble cfg",
          {cfgPreamble, cfgPostamble}, {3'd5, 2'd3});
    check(cfgBurst8 == 1'b0 && cfgCrcEn == 1'b1, "R7", "other cfg kept",
          {cfgBurst8, cfgCrcEn}, {1'b0, 1'b1});
    // R4: visibility exactly one cycle after data
    drive(1'b0, 14'h0006);
    csNIn = 1'b1; caIn = 14'h0001;
    @(posedge clk); #1;
    check(cfgBurst8 == 1'b1, "R4", "burst update timing", cfgBurst8, 1);
    @(negedge clk);
    // R2: reset mid-run restores defaults
    drive(1'b0, 14'h000C);
    rstN = 1'b0;
    #1;
    checkReset();
    @(negedge clk);
    rstN = 1'b1;
    drive(1'b0, 14'h000C);
    check(wrStart && !wrBurst8 && !wrCrcEn, "R2", "write after reset",
          {wrStart, wrBurst8, wrCrcEn}, 3'b100);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule